// File: doc/BRIEF.md
# Raster Sync and Blanking Generator

This block runs on the pixel clock and produces the horizontal sync, vertical sync and data-enable strobes of a video raster, together with the current pixel column, line number and field flag. The raster shape is set by a small byte-wide register file. Each line is made of its active pixels followed by its blanking pixels. Each frame is made of its active lines followed by its blanking lines. The sync pulses sit inside the blanking, and their start is given as a distance back from the total rather than forward from the end of the active region.

Software writes the new geometry at any time through a plain write strobe with an address and a data byte. Writes land in a shadow copy. The running set is replaced from the shadow only when the raster wraps to the start of a frame, so a frame is never built from a mix of old and new values. An interlace mode splits each frame into two fields. The first field has the ceiling of half the vertical total in lines and the second has the floor. The second field's vertical sync edges move to the middle of the line.

There is no pixel data path. All pins are plain control or status signals, so the stream handshake does not apply.

Top module: `rast_timing_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `px_o`, `ln_o` and `field_o` are 0, and the strobes are decoded from the parameter default geometry.
- R2: `px_o` counts 0 to HT-1 and then returns to 0. `ln_o` advances by one each time `px_o` wraps, counts 0 to FT-1, and changes only in the cycle where `px_o` becomes 0. FT is the line count of the current field.
- R3: `de_o` is 1 exactly when `px_o` < HT-HB and `ln_o` < FT-VB.
- R4: The raw horizontal sync is active for `px_o` in [HT-HD, HT-HD+HW).
- R5: In progressive mode and in field 0, the raw vertical sync is active for `ln_o` in [FT-VD, FT-VD+VW).
- R6: Control register bit 0 selects the hsync level: 1 makes `hsync_o` equal the raw sync, 0 inverts it. Control bit 1 does the same for `vsync_o`.
- R7: Control bit 2 enables interlace. When it is set, field 0 has (VT+1)/2 lines and field 1 has VT/2 lines (integer division), and `field_o` toggles at each field wrap. When it is clear, FT=VT and `field_o` stays 0.
- R8: In field 1, the raw vertical sync for a line applies from `px_o` = HT/2 (integer division) onward. Before that pixel, the previous line's window value applies. On line 0 of field 1, the raw vertical sync is inactive before that pixel.
- R9: Register map, with bytes written on `cfg_we`: address 0 holds the control bits. Addresses 1 and 2 hold HT low and high bytes, 3 and 4 hold HB, 5 and 6 hold HD, 7 and 8 hold HW, 9 and 10 hold VT, 11 holds VB, 12 holds VD and 13 holds VW.
- R10: Writes change only the shadow set. The running set takes the whole shadow on the last pixel of the last line of a progressive frame or of field 1. A write in that same cycle is not part of the set taken.
- R11: Writes to addresses 14 and 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Register write byte |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Active-region strobe |
| field_o | output | 1 | Current field, 0 in progressive mode |
| px_o | output | 16 | Pixel column |
| ln_o | output | 16 | Line number within the field |

## Verification
A register write and the frame-boundary transfer can happen in the same clock cycle. The block must then keep the written byte in the shadow set and load the older shadow contents into the running set. The bench watches its own model of the raster and times a write of a new horizontal total so that it is sampled exactly on the wrap edge. It then measures the widest pixel column in the following frame. That column must match the old total, and the column in the frame after must match the new one. A second coincidence, the half-line vsync edge of field 1 against a line wrap, is swept over several sync windows with interlace enabled.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int HW  = 16;  // horizontal field width
  localparam int VW  = 16;  // vertical total width
  localparam int VSW = 8;   // short vertical field width
  localparam int AW  = 4;   // register address width
  localparam int DW  = 8;   // register data width

  typedef struct packed {
    logic           ilace;
    logic           vs_pol;
    logic           hs_pol;
    logic [HW-1:0]  htot;
    logic [HW-1:0]  hblank;
    logic [HW-1:0]  hdelay;
    logic [HW-1:0]  hwidth;
    logic [VW-1:0]  vtot;
    logic [VSW-1:0] vblank;
    logic [VSW-1:0] vdelay;
    logic [VSW-1:0] vwidth;
  } tcfg_t;

  localparam logic [AW-1:0] A_CTRL  = 4'd0;
  localparam logic [AW-1:0] A_HT_L  = 4'd1;
  localparam logic [AW-1:0] A_HT_H  = 4'd2;
  localparam logic [AW-1:0] A_HB_L  = 4'd3;
  localparam logic [AW-1:0] A_HB_H  = 4'd4;
  localparam logic [AW-1:0] A_HD_L  = 4'd5;
  localparam logic [AW-1:0] A_HD_H  = 4'd6;
  localparam logic [AW-1:0] A_HW_L  = 4'd7;
  localparam logic [AW-1:0] A_HW_H  = 4'd8;
  localparam logic [AW-1:0] A_VT_L  = 4'd9;
  localparam logic [AW-1:0] A_VT_H  = 4'd10;
  localparam logic [AW-1:0] A_VB    = 4'd11;
  localparam logic [AW-1:0] A_VD    = 4'd12;
  localparam logic [AW-1:0] A_VWID  = 4'd13;
endpackage

// File: rtl/rtg_cfg_regs.sv
module rtg_cfg_regs
  import rtg_pkg::*;
#(
  parameter tcfg_t DEF = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          load,
  output tcfg_t         act
);
  tcfg_t shadow;

  // Shadow set: byte writes at any time
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= DEF;
    end else if (we) begin
      unique case (addr)
        A_CTRL: begin
          shadow.hs_pol <= wdata[0];
          shadow.vs_pol <= wdata[1];
          shadow.ilace  <= wdata[2];
        end
        A_HT_L: shadow.htot[7:0]      <= wdata;
        A_HT_H: shadow.htot[HW-1:8]   <= wdata[HW-9:0];
        A_HB_L: shadow.hblank[7:0]    <= wdata;
        A_HB_H: shadow.hblank[HW-1:8] <= wdata[HW-9:0];
        A_HD_L: shadow.hdelay[7:0]    <= wdata;
        A_HD_H: shadow.hdelay[HW-1:8] <= wdata[HW-9:0];
        A_HW_L: shadow.hwidth[7:0]    <= wdata;
        A_HW_H: shadow.hwidth[HW-1:8] <= wdata[HW-9:0];
        A_VT_L: shadow.vtot[7:0]      <= wdata;
        A_VT_H: shadow.vtot[VW-1:8]   <= wdata[VW-9:0];
        A_VB:   shadow.vblank         <= wdata[VSW-1:0];
        A_VD:   shadow.vdelay         <= wdata[VSW-1:0];
        A_VWID: shadow.vwidth         <= wdata[VSW-1:0];
        default: ;  // unmapped addresses are dropped
      endcase
    end
  end

  // Running set: whole-set transfer at the frame wrap
  always_ff @(posedge clk) begin
    if (rst) begin
      act <= DEF;
    end else if (load) begin
      act <= shadow;
    end
  end
endmodule

// File: rtl/rtg_hcount.sv
module rtg_hcount
  import rtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  tcfg_t         cfg,
  output logic [HW-1:0] px,
  output logic          wrap,
  output logic          de,
  output logic          sync_raw,
  output logic          second_half
);
  logic [HW:0]   px_next;
  logic [HW-1:0] act_w;
  logic [HW-1:0] sync_start;
  logic [HW:0]   sync_stop;

  always_comb begin
    px_next     = {1'b0, px} + {{HW{1'b0}}, 1'b1};
    wrap        = px_next >= {1'b0, cfg.htot};
    act_w       = cfg.htot - cfg.hblank;
    de          = px < act_w;
    sync_start  = cfg.htot - cfg.hdelay;
    sync_stop   = {1'b0, sync_start} + {1'b0, cfg.hwidth};
    sync_raw    = (px >= sync_start) && ({1'b0, px} < sync_stop);
    second_half = px >= (cfg.htot >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst)       px <= '0;
    else if (wrap) px <= '0;
    else           px <= px_next[HW-1:0];
  end
endmodule

// File: rtl/rtg_vcount.sv
module rtg_vcount
  import rtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  tcfg_t         cfg,
  input  logic          hwrap,
  output logic [VW-1:0] ln,
  output logic          field,
  output logic          frame_end,
  output logic          de,
  output logic          win_cur,
  output logic          win_prev
);
  logic [VW:0]   vt_plus;
  logic [VW-1:0] ftot;
  logic [VW:0]   ln_next;
  logic          vwrap;
  logic [VW-1:0] vs_start;
  logic [VW:0]   vs_stop;
  logic [VW-1:0] ln_prev;

  always_comb begin
    vt_plus = {1'b0, cfg.vtot} + {{VW{1'b0}}, 1'b1};
    if (!cfg.ilace)  ftot = cfg.vtot;
    else if (field)  ftot = cfg.vtot >> 1;
    else             ftot = vt_plus[VW:1];
    ln_next   = {1'b0, ln} + {{VW{1'b0}}, 1'b1};
    vwrap     = ln_next >= {1'b0, ftot};
    frame_end = hwrap && vwrap && (!cfg.ilace || field);
    de        = ln < (ftot - {{(VW-VSW){1'b0}}, cfg.vblank});
    vs_start  = ftot - {{(VW-VSW){1'b0}}, cfg.vdelay};
    vs_stop   = {1'b0, vs_start} + {{(VW-VSW+1){1'b0}}, cfg.vwidth};
    ln_prev   = ln - {{(VW-1){1'b0}}, 1'b1};
    win_cur   = (ln >= vs_start) && ({1'b0, ln} < vs_stop);
    win_prev  = (ln != '0) && (ln_prev >= vs_start) && ({1'b0, ln_prev} < vs_stop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ln    <= '0;
      field <= 1'b0;
    end else if (hwrap) begin
      if (vwrap) begin
        ln    <= '0;
        field <= cfg.ilace && !field;
      end else begin
        ln    <= ln_next[VW-1:0];
      end
    end
  end
endmodule

// File: rtl/rast_timing_gen.sv
module rast_timing_gen
  import rtg_pkg::*;
#(
  parameter logic [HW-1:0]  DEF_HTOT   = 16'd2200,
  parameter logic [HW-1:0]  DEF_HBLANK = 16'd280,
  parameter logic [HW-1:0]  DEF_HDELAY = 16'd192,
  parameter logic [HW-1:0]  DEF_HWIDTH = 16'd44,
  parameter logic [VW-1:0]  DEF_VTOT   = 16'd1125,
  parameter logic [VSW-1:0] DEF_VBLANK = 8'd45,
  parameter logic [VSW-1:0] DEF_VDELAY = 8'd41,
  parameter logic [VSW-1:0] DEF_VWIDTH = 8'd5,
  parameter logic [2:0]     DEF_CTRL   = 3'b011
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [7:0]    cfg_wdata,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          field_o,
  output logic [15:0]   px_o,
  output logic [15:0]   ln_o
);
  localparam tcfg_t DEF_CFG = '{
    ilace:  DEF_CTRL[2], vs_pol: DEF_CTRL[1], hs_pol: DEF_CTRL[0],
    htot:   DEF_HTOT,    hblank: DEF_HBLANK,  hdelay: DEF_HDELAY,
    hwidth: DEF_HWIDTH,  vtot:   DEF_VTOT,    vblank: DEF_VBLANK,
    vdelay: DEF_VDELAY,  vwidth: DEF_VWIDTH
  };

  tcfg_t         act_cfg;
  logic [HW-1:0] px;
  logic [VW-1:0] ln;
  logic          hwrap, hde, hs_raw, second_half;
  logic          field, frame_end, vde, win_cur, win_prev;
  logic          vs_raw;

  rtg_cfg_regs #(.DEF(DEF_CFG)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .load(frame_end), .act(act_cfg)
  );

  rtg_hcount u_h (
    .clk(clk), .rst(rst), .cfg(act_cfg), .px(px), .wrap(hwrap), .de(hde),
    .sync_raw(hs_raw), .second_half(second_half)
  );

  rtg_vcount u_v (
    .clk(clk), .rst(rst), .cfg(act_cfg), .hwrap(hwrap), .ln(ln), .field(field),
    .frame_end(frame_end), .de(vde), .win_cur(win_cur), .win_prev(win_prev)
  );

  // Field 1 moves its vertical sync edges to the middle of the line
  always_comb begin
    if (act_cfg.ilace && field) vs_raw = second_half ? win_cur : win_prev;
    else                        vs_raw = win_cur;
  end

  assign hsync_o = act_cfg.hs_pol ? hs_raw : !hs_raw;
  assign vsync_o = act_cfg.vs_pol ? vs_raw : !vs_raw;
  assign de_o    = hde && vde;
  assign field_o = field;
  assign px_o    = px;
  assign ln_o    = ln;
endmodule

// File: rtl/rtg_chk.sv
module rtg_chk
  import rtg_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [15:0] px,
  input logic [15:0] ln,
  input logic        field,
  input logic        de,
  input tcfg_t       act
);
  assert_px_step_R2: assert property (@(posedge clk) disable iff (rst)
    (px != 16'd0) |-> (px == $past(px) + 16'd1));

  assert_ln_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (px != 16'd0) |-> $stable(ln));

  assert_field_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (px != 16'd0 || ln != 16'd0) |-> $stable(field));

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (px != 16'd0 || ln != 16'd0 || field) |-> $stable(act));

  assert_de_prefix_R3: assert property (@(posedge clk) disable iff (rst)
    (de && px != 16'd0) |-> $past(de));
endmodule

bind rast_timing_gen rtg_chk u_chk (
  .clk(clk), .rst(rst), .px(px_o), .ln(ln_o), .field(field_o), .de(de_o),
  .act(act_cfg)
);

// File: tb/rast_timing_gen_tb.sv
`timescale 1ns/1ps
module rast_timing_gen_tb;
  import rtg_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic hsync_o, vsync_o, de_o, field_o;
  logic [15:0] px_o, ln_o;

  always #2 clk = ~clk;  // 250 MHz

  localparam tcfg_t DEFC = '{ilace:1'b0, vs_pol:1'b0, hs_pol:1'b1,
    htot:16'd12, hblank:16'd4, hdelay:16'd3, hwidth:16'd2,
    vtot:16'd8, vblank:8'd2, vdelay:8'd2, vwidth:8'd1};

  rast_timing_gen #(
    .DEF_HTOT(16'd12), .DEF_HBLANK(16'd4), .DEF_HDELAY(16'd3), .DEF_HWIDTH(16'd2),
    .DEF_VTOT(16'd8), .DEF_VBLANK(8'd2), .DEF_VDELAY(8'd2), .DEF_VWIDTH(8'd1),
    .DEF_CTRL(3'b001)
  ) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .field_o(field_o),
    .px_o(px_o), .ln_o(ln_o)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, frames = 0, max_px = 0;
  bit chk_en = 1'b0;

  task automatic check(input bit ok, input string tag, input int act_v, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act_v, exp_v, $time);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // Arithmetic reference from the requirements
  function automatic int ftot_f(tcfg_t c, bit f);
    if (!c.ilace) return int'(c.vtot);
    return f ? int'(c.vtot) / 2 : (int'(c.vtot) + 1) / 2;
  endfunction

  function automatic bit win_f(tcfg_t c, bit f, int l);
    int s;
    s = ftot_f(c, f) - int'(c.vdelay);
    return (l >= s) && (l < s + int'(c.vwidth));
  endfunction

  function automatic tcfg_t wr_f(tcfg_t c, logic [3:0] a, logic [7:0] d);
    tcfg_t r = c;
    case (a)  // R9 map
      4'd0:  begin r.hs_pol = d[0]; r.vs_pol = d[1]; r.ilace = d[2]; end
      4'd1:  r.htot[7:0] = d;   4'd2:  r.htot[15:8] = d;
      4'd3:  r.hblank[7:0] = d; 4'd4:  r.hblank[15:8] = d;
      4'd5:  r.hdelay[7:0] = d; 4'd6:  r.hdelay[15:8] = d;
      4'd7:  r.hwidth[7:0] = d; 4'd8:  r.hwidth[15:8] = d;
      4'd9:  r.vtot[7:0] = d;   4'd10: r.vtot[15:8] = d;
      4'd11: r.vblank = d;      4'd12: r.vdelay = d;
      4'd13: r.vwidth = d;
      default: ;  // R11
    endcase
    return r;
  endfunction

  int m_px = 0, m_ln = 0;
  bit m_fld = 1'b0;
  tcfg_t m_sh = DEFC, m_act = DEFC;

  function automatic bit m_fe_next();
    return (m_px + 1 >= int'(m_act.htot)) && (m_ln + 1 >= ftot_f(m_act, m_fld)) &&
           (!m_act.ilace || m_fld);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_px <= 0; m_ln <= 0; m_fld <= 1'b0; m_sh <= DEFC; m_act <= DEFC;
    end else begin
      bit hw, vw;
      hw = m_px + 1 >= int'(m_act.htot);
      vw = m_ln + 1 >= ftot_f(m_act, m_fld);
      if (cfg_we) m_sh <= wr_f(m_sh, cfg_addr, cfg_wdata);
      if (hw && vw && (!m_act.ilace || m_fld)) begin
        m_act <= m_sh;
        frames <= frames + 1;
      end
      if (hw) begin
        m_px <= 0;
        if (vw) begin m_ln <= 0; m_fld <= m_act.ilace && !m_fld; end
        else m_ln <= m_ln + 1;
      end else m_px <= m_px + 1;
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      int ft, hs0; bit e_de, e_hs, e_vs;
      ft = ftot_f(m_act, m_fld);
      e_de = (m_px < int'(m_act.htot) - int'(m_act.hblank)) && (m_ln < ft - int'(m_act.vblank));
      hs0 = int'(m_act.htot) - int'(m_act.hdelay);
      e_hs = (m_px >= hs0) && (m_px < hs0 + int'(m_act.hwidth));
      e_hs = m_act.hs_pol ? e_hs : !e_hs;
      if (m_act.ilace && m_fld)
        e_vs = (m_px >= int'(m_act.htot) / 2) ? win_f(m_act, m_fld, m_ln)
                                               : (m_ln != 0 && win_f(m_act, m_fld, m_ln - 1));
      else e_vs = win_f(m_act, m_fld, m_ln);
      e_vs = m_act.vs_pol ? e_vs : !e_vs;
      check(int'(px_o) == m_px, "R2 px", int'(px_o), m_px);
      check(int'(ln_o) == m_ln, "R2 ln", int'(ln_o), m_ln);
      check(field_o == m_fld, "R7 field", int'(field_o), int'(m_fld));
      check(de_o == e_de, "R3 de", int'(de_o), int'(e_de));
      check(hsync_o == e_hs, "R4 R6 hsync", int'(hsync_o), int'(e_hs));
      check(vsync_o == e_vs, (m_act.ilace && m_fld) ? "R8 R6 vsync" : "R5 R6 vsync",
            int'(vsync_o), int'(e_vs));
      if (int'(px_o) > max_px) max_px = int'(px_o);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      summary();
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic wait_frames(input int n);
    int s;
    s = frames;
    while (frames < s + n) @(negedge clk);
    #1;
  endtask

  task automatic set_cfg(input int ht, hb, hd, hw, vt, vb, vd, vwd, input logic [2:0] ctl);
    wr(4'd0, {5'd0, ctl});
    wr(4'd1, 8'(ht)); wr(4'd2, 8'(ht >> 8));
    wr(4'd3, 8'(hb)); wr(4'd4, 8'(hb >> 8));
    wr(4'd5, 8'(hd)); wr(4'd6, 8'(hd >> 8));
    wr(4'd7, 8'(hw)); wr(4'd8, 8'(hw >> 8));
    wr(4'd9, 8'(vt)); wr(4'd10, 8'(vt >> 8));
    wr(4'd11, 8'(vb)); wr(4'd12, 8'(vd)); wr(4'd13, 8'(vwd));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, defaults decoded (sync start px 9, vsync window line 6)
    check(px_o == 16'd0, "R1 px", int'(px_o), 0);
    check(ln_o == 16'd0, "R1 ln", int'(ln_o), 0);
    check(field_o == 1'b0, "R1 field", int'(field_o), 0);
    check(de_o == 1'b1, "R1 de", int'(de_o), 1);
    check(hsync_o == 1'b0, "R1 hsync", int'(hsync_o), 0);
    check(vsync_o == 1'b1, "R1 vsync", int'(vsync_o), 1);
    #1 rst = 1'b0;
    chk_en = 1'b1;
    wait_frames(2);

    // R10: mid-frame write of a larger total stays out of this frame
    repeat (20) @(negedge clk);
    #1 max_px = 0;
    wr(4'd1, 8'd20);
    wait_frames(1);
    check(max_px == 11, "R10 old total kept", max_px, 11);
    max_px = 0;
    wait_frames(1);
    check(max_px == 19, "R9 new total", max_px, 19);

    // R11: unmapped addresses change nothing
    wr(4'd14, 8'hFF); wr(4'd15, 8'h00);
    wait_frames(1);
    max_px = 0;
    wait_frames(1);
    check(max_px == 19, "R11 unmapped write", max_px, 19);

    // R10: write sampled on the same edge as the transfer
    while (!m_fe_next()) @(negedge clk);
    #1 cfg_we = 1'b1; cfg_addr = 4'd1; cfg_wdata = 8'd14;
    @(negedge clk); #1 cfg_we = 1'b0; max_px = 0;
    wait_frames(1);
    check(max_px == 19, "R10 coincident write deferred", max_px, 19);
    max_px = 0;
    wait_frames(1);
    check(max_px == 13, "R10 coincident write lands", max_px, 13);

    // Sweep of sync windows, polarities and interlace (R4 R5 R6 R7 R8)
    for (int hd = 1; hd <= 3; hd++)
      for (int hw = 1; hw <= 3; hw++)
        for (int vd = 1; vd <= 3; vd++)
          for (int vwd = 1; vwd <= 2; vwd++) begin
            logic [2:0] ctl;
            ctl = 3'((hd + hw + vd + vwd) % 8);
            set_cfg(12, 4, hd, hw, ctl[2] ? 9 : 8, 2, vd, vwd, ctl);
            wait_frames(2);
          end

    summary();
  end
endmodule